// File: doc/BRIEF.md
# Bitfield Deposit Unit

This unit writes a contiguous bit field into a data word. It takes the low-order bits of a source value and places them at a chosen start position and length inside the destination word. The result comes out one clock after the operation is presented. Two policies govern the bits outside the field. In merge mode they keep the previous destination value. In zero mode they are cleared.

The source can come from a register operand. It can also come from a small signed immediate that is sign-extended to the word width. With the immediate source, depositing all ones or all zeros sets or clears a single bit or a whole field. The start position comes either from the instruction immediate or from a separate shift-amount register input. Instruction decode is outside the block: every selection arrives as a ready-made control bit.

A field may reach past the end of the word. In that case it is clipped. Only destination bits that lie inside the word change, and the source bits aimed beyond the edge are dropped.

Top module: `pbd_deposit`

## Requirements
- R1: While `rst_n` is low, `res` is all zeros and `res_valid` is 0.
- R2: An operation presented with `op_valid`=1 at a rising edge appears on `res` and `res_valid`=1 right after that edge. After an edge with `op_valid`=0, `res_valid` is 0 and `res` keeps its previous value.
- R3: Bit positions are numbered from 0 at the most significant bit (`res[W-1]`). The field covers positions start..start+len-1. Source bit k (counted from its LSB) lands at position start+len-1-k, so the source LSB lands on the rightmost field bit.
- R4: `len_code` is log2(W) bits wide. Code 0 means a length of W. Any other code c means a length of c.
- R5: With `zero_fill`=0, every bit outside the field equals the matching bit of `old_dst`.
- R6: With `zero_fill`=1, every bit outside the field is 0.
- R7: Source bits at or above the field length do not affect the result.
- R8: When start+len-1 > W-1, positions beyond W-1 are not written and the source bits aimed at them are dropped. The in-word part of the field is still written as in R3.
- R9: With `sel_sar`=1 the start comes from `sar_start`. With `sel_sar`=0 it comes from `start_imm`.
- R10: With `sel_imm`=1 the source is `imm_src` sign-extended from IMMW bits to W bits (`imm_src[IMMW-1]` is the sign bit), and `src_reg` has no effect.
- R11: An all-ones immediate sets every field bit to 1, and an all-zeros immediate clears every field bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| zero_fill | input | 1 | 1: clear bits outside the field; 0: keep `old_dst` there |
| sel_sar | input | 1 | 1: start taken from `sar_start`; 0: from `start_imm` |
| sel_imm | input | 1 | 1: source is the sign-extended `imm_src`; 0: `src_reg` |
| start_imm | input | log2(W) | Start position from the instruction immediate (0 = MSB) |
| sar_start | input | log2(W) | Start position from the shift-amount register |
| len_code | input | log2(W) | Field length, with 0 meaning W |
| imm_src | input | IMMW | Signed immediate source value |
| src_reg | input | W | Register source value |
| old_dst | input | W | Previous destination contents |
| res_valid | output | 1 | `res` holds a fresh result |
| res | output | W | New destination value |

## Verification
The bench builds the unit with its defaults: W=32 and IMMW=5. With these values the full space of start and length codes, 32 by 32, is small enough to sweep completely. The sweep runs in both fill modes and with both source types. It therefore reaches every clipped field, from a single overhanging bit up to a full-word field starting at position 31. The 5-bit immediate also makes the all-ones and all-zeros set/clear patterns and both sign-extension cases directly reachable.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

  // Policy for the bits of the destination that lie outside the field.
  typedef enum logic {
    FILL_KEEP  = 1'b0,
    FILL_CLEAR = 1'b1
  } fill_e;

  // Where the deposited value comes from.
  typedef enum logic {
    SRC_REG = 1'b0,
    SRC_IMM = 1'b1
  } src_e;

endpackage

// File: rtl/pbd_operand_sel.sv
module pbd_operand_sel #(
  parameter int W    = 32,
  parameter int IMMW = 5,
  localparam int PW  = $clog2(W)
) (
  input  logic            sel_sar,
  input  logic            sel_imm,
  input  logic [PW-1:0]   start_imm,
  input  logic [PW-1:0]   sar_start,
  input  logic [IMMW-1:0] imm_src,
  input  logic [W-1:0]    src_reg,
  output logic [PW-1:0]   start_pos,
  output logic [W-1:0]    src_val
);
  import pbd_pkg::*;

  // Widen a signed immediate to the word width.
  function automatic logic [W-1:0] sext_imm(input logic [IMMW-1:0] v);
    return {{(W-IMMW){v[IMMW-1]}}, v};
  endfunction

  src_e src_kind;
  assign src_kind  = src_e'(sel_imm);
  assign start_pos = sel_sar ? sar_start : start_imm;
  assign src_val   = (src_kind == SRC_IMM) ? sext_imm(imm_src) : src_reg;

endmodule

// File: rtl/pbd_field_gen.sv
module pbd_field_gen #(
  parameter int W   = 32,
  localparam int PW = $clog2(W),
  localparam int DW = 2 * W
) (
  input  logic [PW-1:0] start_pos,
  input  logic [PW-1:0] len_code,
  input  logic [W-1:0]  src_val,
  output logic [PW:0]   eff_len,
  output logic [W-1:0]  fmask,
  output logic [W-1:0]  fplaced
);

  // Length code 0 stands for a full word.
  function automatic logic [PW:0] decode_len(input logic [PW-1:0] c);
    return (c == '0) ? (PW+1)'(W) : {1'b0, c};
  endfunction

  // Keep the low n bits of v (n in 1..W).
  function automatic logic [W-1:0] low_bits(input logic [W-1:0] v, input logic [PW:0] n);
    logic [W-1:0] ones;
    ones = {W{1'b1}} >> (W - int'(n));
    return v & ones;
  endfunction

  // Position a right-justified value so its LSB sits at MSB-numbered
  // position p+n-1. The work is done in a double-width word: the upper
  // half is the result, and whatever falls into the lower half is the
  // part clipped off past the LSB end of the word.
  function automatic logic [W-1:0] place(input logic [W-1:0] v,
                                         input logic [PW-1:0] p,
                                         input logic [PW:0] n);
    logic [DW-1:0] wide;
    int            sh;
    sh   = DW - int'(p) - int'(n);
    wide = {{W{1'b0}}, v} << sh;
    return wide[DW-1:W];
  endfunction

  assign eff_len = decode_len(len_code);
  assign fmask   = place({W{1'b1}} >> (W - int'(eff_len)), start_pos, eff_len);
  assign fplaced = place(low_bits(src_val, eff_len), start_pos, eff_len);

endmodule

// File: rtl/pbd_merge.sv
module pbd_merge #(
  parameter int W = 32
) (
  input  logic         zero_fill,
  input  logic [W-1:0] fmask,
  input  logic [W-1:0] fplaced,
  input  logic [W-1:0] old_dst,
  output logic [W-1:0] merged
);
  import pbd_pkg::*;

  fill_e fill;
  assign fill = fill_e'(zero_fill);

  // One selector per bit: field data inside, kept or cleared outside.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (fmask[i])                merged[i] = fplaced[i];
      else if (fill == FILL_CLEAR) merged[i] = 1'b0;
      else                         merged[i] = old_dst[i];
    end
  end

endmodule

// File: rtl/pbd_deposit.sv
module pbd_deposit #(
  parameter int W    = 32,
  parameter int IMMW = 5,
  localparam int PW  = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            zero_fill,
  input  logic            sel_sar,
  input  logic            sel_imm,
  input  logic [PW-1:0]   start_imm,
  input  logic [PW-1:0]   sar_start,
  input  logic [PW-1:0]   len_code,
  input  logic [IMMW-1:0] imm_src,
  input  logic [W-1:0]    src_reg,
  input  logic [W-1:0]    old_dst,
  output logic            res_valid,
  output logic [W-1:0]    res
);

  logic [PW-1:0] start_pos;
  logic [W-1:0]  src_val;
  logic [PW:0]   eff_len;
  logic [W-1:0]  fmask;
  logic [W-1:0]  fplaced;
  logic [W-1:0]  merged;

  pbd_operand_sel #(.W(W), .IMMW(IMMW)) u_opsel (
    .sel_sar   (sel_sar),
    .sel_imm   (sel_imm),
    .start_imm (start_imm),
    .sar_start (sar_start),
    .imm_src   (imm_src),
    .src_reg   (src_reg),
    .start_pos (start_pos),
    .src_val   (src_val)
  );

  pbd_field_gen #(.W(W)) u_field (
    .start_pos (start_pos),
    .len_code  (len_code),
    .src_val   (src_val),
    .eff_len   (eff_len),
    .fmask     (fmask),
    .fplaced   (fplaced)
  );

  pbd_merge #(.W(W)) u_merge (
    .zero_fill (zero_fill),
    .fmask     (fmask),
    .fplaced   (fplaced),
    .old_dst   (old_dst),
    .merged    (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res <= merged;
    end
  end

endmodule

// File: rtl/pbd_deposit_chk.sv
module pbd_deposit_chk #(
  parameter int W    = 32,
  parameter int IMMW = 5,
  localparam int PW  = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            zero_fill,
  input logic            sel_imm,
  input logic [IMMW-1:0] imm_src,
  input logic [W-1:0]    old_dst,
  input logic            res_valid,
  input logic [W-1:0]    res,
  input logic [PW:0]     eff_len,
  input logic [W-1:0]    fmask,
  input logic [W-1:0]    fplaced
);

  // R2: result qualifier follows the operation by one cycle.
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R2: an idle cycle leaves the result untouched.
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && $stable(res)));

  // R3: the field bits of the result carry the positioned source.
  p_field_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ((res & $past(fmask)) == $past(fplaced)));

  // R5: merge mode keeps the old destination outside the field.
  p_outside_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !zero_fill) |=> ((res & ~$past(fmask)) == ($past(old_dst) & ~$past(fmask))));

  // R6: zero mode clears everything outside the field.
  p_outside_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && zero_fill) |=> ((res & ~$past(fmask)) == '0));

  // R8: clipping can only shrink the field, never widen it.
  p_mask_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fmask) <= int'(eff_len));

  // R11: an all-ones immediate fills the whole field with ones.
  p_imm_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sel_imm && (imm_src == '1)) |=> ((res & $past(fmask)) == $past(fmask)));

endmodule

bind pbd_deposit pbd_deposit_chk #(.W(W), .IMMW(IMMW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .zero_fill (zero_fill),
  .sel_imm   (sel_imm),
  .imm_src   (imm_src),
  .old_dst   (old_dst),
  .res_valid (res_valid),
  .res       (res),
  .eff_len   (eff_len),
  .fmask     (fmask),
  .fplaced   (fplaced)
);

// File: tb/tb_pbd_deposit.sv
`timescale 1ns/1ps
module tb_pbd_deposit;
  localparam int W    = 32;
  localparam int IMMW = 5;
  localparam int PW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic            zero_fill = 1'b0;
  logic            sel_sar = 1'b0;
  logic            sel_imm = 1'b0;
  logic [PW-1:0]   start_imm = '0;
  logic [PW-1:0]   sar_start = '0;
  logic [PW-1:0]   len_code = '0;
  logic [IMMW-1:0] imm_src = '0;
  logic [W-1:0]    src_reg = '0;
  logic [W-1:0]    old_dst = '0;
  logic            res_valid;
  logic [W-1:0]    res;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  pbd_deposit #(.W(W), .IMMW(IMMW)) dut (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] old_v;
    logic [31:0] src_v;
    logic [4:0]  start;
    logic [4:0]  lcode;
    logic        zf;
    logic [31:0] exp_v;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'h00000000, 32'h000000FF, 5'd24, 5'd8, 1'b0, 32'h000000FF}, // R3
    '{32'hFFFFFFFF, 32'h00000000, 5'd0,  5'd4, 1'b0, 32'h0FFFFFFF}, // R5
    '{32'h12345678, 32'h0000000A, 5'd8,  5'd4, 1'b1, 32'h00A00000}, // R6
    '{32'h12345678, 32'hFFFFFFF5, 5'd28, 5'd4, 1'b0, 32'h12345675}, // R7
    '{32'hFFFFFFFF, 32'h00000009, 5'd30, 5'd4, 1'b0, 32'hFFFFFFFE}, // R8
    '{32'h13572468, 32'hDEADBEEF, 5'd0,  5'd0, 1'b0, 32'hDEADBEEF}, // R4
    '{32'h00000000, 32'h00000001, 5'd0,  5'd1, 1'b1, 32'h80000000}, // R3
    '{32'h00000000, 32'h00000001, 5'd31, 5'd1, 1'b0, 32'h00000001}  // R8
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-by-bit restatement of the deposit rules (MSB is position 0).
  function automatic logic [W-1:0] model(input logic [W-1:0] o, input logic [W-1:0] s,
                                         input int p, input int lc, input bit zf);
    logic [W-1:0] r;
    int n;
    n = (lc == 0) ? W : lc;
    for (int q = 0; q < W; q++) begin
      if (q >= p && q <= p + n - 1) r[W-1-q] = s[p + n - 1 - q];
      else                          r[W-1-q] = zf ? 1'b0 : o[W-1-q];
    end
    return r;
  endfunction

  task automatic do_op(input logic [W-1:0] o, input logic [W-1:0] s, input logic [IMMW-1:0] im,
                       input int st, input int sar, input int lc,
                       input bit zf, input bit use_sar, input bit use_imm);
    @(negedge clk);
    op_valid  = 1'b1;
    old_dst   = o;
    src_reg   = s;
    imm_src   = im;
    start_imm = PW'(st);
    sar_start = PW'(sar);
    len_code  = PW'(lc);
    zero_fill = zf;
    sel_sar   = use_sar;
    sel_imm   = use_imm;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 res in reset", res, '0);
    check("R1 valid in reset", {31'b0, res_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table
    foreach (TBL[i]) begin
      do_op(TBL[i].old_v, TBL[i].src_v, '0, int'(TBL[i].start), 0, int'(TBL[i].lcode),
            TBL[i].zf, 1'b0, 1'b0);
      check($sformatf("R2 valid vec%0d", i), {31'b0, res_valid}, 32'h1);
      check($sformatf("R3/R4/R5/R6/R7/R8 vec%0d", i), res, TBL[i].exp_v);
    end

    // R2: idle cycle holds the result
    held = res;
    @(negedge clk);
    op_valid = 1'b0;
    src_reg  = 32'h55555555;
    old_dst  = 32'hAAAAAAAA;
    @(posedge clk);
    #1;
    check("R2 hold res", res, held);
    check("R2 valid drops", {31'b0, res_valid}, 32'h0);

    // R9: start from the shift-amount register
    do_op(32'h12345678, 32'h0000000A, '0, 0, 8, 4, 1'b1, 1'b1, 1'b0);
    check("R9 sar start", res, 32'h00A00000);
    do_op(32'h12345678, 32'h0000000A, '0, 8, 0, 4, 1'b1, 1'b0, 1'b0);
    check("R9 imm start", res, 32'h00A00000);

    // R10/R11: immediate source, register source ignored
    do_op(32'h00000000, 32'h00000000, 5'b11111, 4, 0, 8, 1'b1, 1'b0, 1'b1);
    check("R11 set field", res, 32'h0FF00000);
    do_op(32'hFFFFFFFF, 32'hFFFFFFFF, 5'b00000, 16, 0, 8, 1'b0, 1'b0, 1'b1);
    check("R11 clear field", res, 32'hFFFF00FF);
    do_op(32'h00000000, 32'hFFFFFFFF, 5'b01010, 24, 0, 8, 1'b1, 1'b0, 1'b1);
    check("R10 positive imm", res, 32'h0000000A);
    do_op(32'h00000000, 32'h00000000, 5'b10000, 24, 0, 8, 1'b0, 1'b0, 1'b1);
    check("R10 negative imm", res, 32'h000000F0);

    // Full sweep: every start/length, both fill modes, both sources
    for (int p = 0; p < W; p++) begin
      for (int lc = 0; lc < W; lc++) begin
        for (int m = 0; m < 4; m++) begin
          logic [W-1:0] o, s, sv;
          logic [IMMW-1:0] im;
          o  = 32'h9E3779B9 ^ (p * 32'h01010101) ^ (lc << 7);
          s  = 32'hA5C396F1 ^ (lc * 32'h00110011) ^ (p << 13);
          im = IMMW'(p + 3 * lc);
          sv = m[1] ? {{(W-IMMW){im[IMMW-1]}}, im} : s;
          do_op(o, s, im, p, 0, lc, m[0], 1'b0, m[1]);
          check($sformatf("R3/R5/R6/R8/R10 sweep p=%0d lc=%0d m=%0d", p, lc, m),
                res, model(o, sv, p, lc, m[0]));
        end
      end
    end

    // R1: reset in mid-run clears the result
    @(negedge clk);
    op_valid = 1'b0;
    rst_n    = 1'b0;
    #1;
    check("R1 mid-run reset res", res, '0);
    check("R1 mid-run reset valid", {31'b0, res_valid}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule